// File: doc/BRIEF.md
# Streaming CRC-8 Accumulator

This block folds a stream of bytes into an 8-bit cyclic redundancy check. It uses the reflected polynomial of the single-wire sensor bus: generator constant 0x8C, data bits taken least significant first, register seeded with zero. It accepts one byte in every clock cycle in which the producer offers one. The running value is available at all times. A synchronous clear input starts a new message.

To check a received frame, the receiver clears the block and streams every payload byte. It then streams the CRC byte that arrived with the frame. When the frame is intact the register returns to zero and the pass flag rises. Which bytes take part in the check, and where frames begin and end, is for the surrounding logic to decide.

The input side is a valid/ready stream. The block never applies back-pressure: `in_ready` is high in every cycle out of reset. A byte is consumed on each rising clock edge where `in_valid` is high. The producer may hold `in_valid` high for any number of cycles to stream back to back, and may drop it for any number of idle cycles.

Top module: `crc8_stream_check`

## Requirements
- R1: After reset, `crc_out` is 0x00, `check_ok` is 0 and `in_ready` is 1.
- R2: A byte accepted with `clr` low changes `crc_out` to T[crc_out XOR in_data], where T is the per-byte step. T is defined by eight bit steps taken least significant data bit first: fb = crc[0] XOR bit; crc = crc >> 1; if fb then crc ^= 0x8C. The step has these fixed values: T[0]=0, T[1]=94, T[2]=188, T[3]=226, T[64]=70, T[128]=140, T[255]=53 (decimal).
- R3: In a cycle where neither `in_valid` nor `clr` is high, `crc_out` and `check_ok` keep their values.
- R4: `clr` high with `in_valid` low sets `crc_out` to 0x00 and `check_ok` to 0 on the next edge.
- R5: `clr` and `in_valid` high in the same cycle give `crc_out` = T[in_data], as if the register had already been zero.
- R6: `check_ok` is 1 exactly when `crc_out` is 0x00 and at least one byte has been accepted since the last reset or clear-only cycle.
- R7: `in_ready` stays 1 at all times out of reset. A byte is accepted on every edge with `in_valid` high, so back-to-back bytes are all absorbed.
- R8: Streaming a message followed by its own CRC byte leaves `crc_out` at 0x00 with `check_ok` at 1. One example is the 8-byte identifier 02 1C B8 01 00 00 00 A2 (hex), whose first seven bytes give CRC 0xA2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear, starts a new message |
| in_valid | input | 1 | Producer offers a byte |
| in_ready | output | 1 | Block accepts a byte (always 1 out of reset) |
| in_data | input | 8 | Byte offered by the producer |
| crc_out | output | 8 | Running CRC register |
| check_ok | output | 1 | Register is zero after at least one byte |

## Verification
Assertions check the following on every cycle:
- the register and flag hold when there is neither a byte nor a clear;
- a clear-only cycle zeroes both;
- the pass flag never rises while the register is non-zero;
- an accepted byte always marks the message as started.

The numeric correctness of the step can only be shown by the bench's scenarios. These are an exhaustive sweep of every byte value after a same-cycle clear, every byte value on top of several non-zero register contents, and the golden table entries. Random back-to-back strings with idle gaps and the self-checking identifier frame are also only covered there.

// File: rtl/crc8_pkg.sv
package crc8_pkg;
  localparam int CRC_W = 8;
  localparam logic [CRC_W-1:0] CRC_POLY = 8'h8C;
  localparam logic [CRC_W-1:0] CRC_SEED = 8'h00;
  typedef logic [CRC_W-1:0] crc_t;
endpackage

// File: rtl/crc8_lfsr_step.sv
// Combinational byte step: unrolled reflected LFSR, LSB of data first.
module crc8_lfsr_step #(
  parameter int          W    = 8,
  parameter int          DW   = 8,
  parameter logic [W-1:0] POLY = 8'h8C
) (
  input  logic [W-1:0]  crc_i,
  input  logic [DW-1:0] data_i,
  output logic [W-1:0]  crc_o
);
  logic [W-1:0] stage [DW+1];

  assign stage[0] = crc_i;

  for (genvar i = 0; i < DW; i++) begin : g_bit
    logic fb;
    assign fb = stage[i][0] ^ data_i[i];
    assign stage[i+1] = (stage[i] >> 1) ^ (fb ? POLY : '0);
  end

  assign crc_o = stage[DW];
endmodule

// File: rtl/crc8_acc_reg.sv
// Holds the running CRC and the "message started" flag.
module crc8_acc_reg #(
  parameter int           W    = 8,
  parameter logic [W-1:0] SEED = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         take,
  input  logic [W-1:0] next_crc,
  output logic [W-1:0] crc_q,
  output logic         started_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q     <= SEED;
      started_q <= 1'b0;
    end else if (take) begin
      crc_q     <= next_crc;
      started_q <= 1'b1;
    end else if (clr) begin
      crc_q     <= SEED;
      started_q <= 1'b0;
    end
  end

  // R3: nothing offered and no clear -> state holds
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !clr) |=> ($stable(crc_q) && $stable(started_q)));

  // R4: clear-only cycle returns to seed
  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !take) |=> (crc_q == SEED && !started_q));

  // R6: an accepted byte always marks the message as started
  a_r6_started: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> started_q);
endmodule

// File: rtl/crc8_stream_check.sv
module crc8_stream_check
  import crc8_pkg::*;
#(
  parameter int   W    = CRC_W,
  parameter crc_t POLY = CRC_POLY,
  parameter crc_t SEED = CRC_SEED
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic [W-1:0] crc_out,
  output logic         check_ok
);
  logic [W-1:0] base_crc;
  logic [W-1:0] step_crc;
  logic         take;
  logic         started;

  assign in_ready = 1'b1;
  assign take     = in_valid && in_ready;

  // R5: a same-cycle clear makes the step start from the seed
  assign base_crc = clr ? SEED : crc_out;

  crc8_lfsr_step #(.W(W), .DW(W), .POLY(POLY)) u_step (
    .crc_i  (base_crc),
    .data_i (in_data),
    .crc_o  (step_crc)
  );

  crc8_acc_reg #(.W(W), .SEED(SEED)) u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .take      (take),
    .next_crc  (step_crc),
    .crc_q     (crc_out),
    .started_q (started)
  );

  assign check_ok = started && (crc_out == '0);

  // R6: pass flag never high with a non-zero register
  a_r6_ok_zero: assert property (@(posedge clk) disable iff (!rst_n)
    check_ok |-> (crc_out == '0));

  // R7: every offered byte is accepted
  a_r7_accept: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> in_ready);
endmodule

// File: tb/tb_crc8_stream_check.sv
module tb_crc8_stream_check;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic [7:0] crc_out;
  logic       check_ok;

  int total = 0;
  int bad   = 0;
  logic [7:0] m_crc = 8'h00;
  logic       m_started = 1'b0;
  logic [7:0] table_m [256];

  always #10 clk = ~clk;

  crc8_stream_check dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .crc_out(crc_out),
    .check_ok(check_ok)
  );

  function automatic logic [7:0] ref_step(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    logic [7:0] x;
    r = 8'h00;
    x = c ^ d;
    // arithmetic form: shift value x through polynomial, LSB first
    for (int b = 0; b < 8; b++) begin
      if ((r[0] ^ x[b]) == 1'b1) r = (r >> 1) ^ 8'h8C;
      else r = r >> 1;
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic c, input logic v, input logic [7:0] d);
    @(negedge clk);
    clr = c; in_valid = v; in_data = d;
    @(posedge clk);
    #1;
    if (v) begin
      m_crc = table_m[(c ? 8'h00 : m_crc) ^ d];
      m_started = 1'b1;
    end else if (c) begin
      m_crc = 8'h00;
      m_started = 1'b0;
    end
    @(negedge clk);
    clr = 1'b0; in_valid = 1'b0;
  endtask

  task automatic expect_state(input string req);
    chk(req, crc_out, m_crc);
    chk(req, {7'd0, check_ok}, {7'd0, m_started && (m_crc == 8'h00)});
  endtask

  initial begin
    #3_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] rom [8];
    for (int i = 0; i < 256; i++) table_m[i] = ref_step(8'h00, i[7:0]);
    rom[0]=8'h02; rom[1]=8'h1C; rom[2]=8'hB8; rom[3]=8'h01;
    rom[4]=8'h00; rom[5]=8'h00; rom[6]=8'h00; rom[7]=8'hA2;

    // golden table values (R2)
    chk("R2 T1", table_m[1], 8'd94);   chk("R2 T2", table_m[2], 8'd188);
    chk("R2 T3", table_m[3], 8'd226);  chk("R2 T255", table_m[255], 8'd53);
    chk("R2 T64", table_m[64], 8'd70); chk("R2 T128", table_m[128], 8'd140);

    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 crc", crc_out, 8'h00);
    chk("R1 ok", {7'd0, check_ok}, 8'h00);
    chk("R1 ready", {7'd0, in_ready}, 8'h01);
    @(negedge clk); rst_n = 1'b1;

    // R2 golden through hardware from zero register
    cyc(1'b0, 1'b1, 8'd1);   chk("R2 hw T1", crc_out, 8'd94);
    cyc(1'b1, 1'b0, 8'd0);   expect_state("R4 clear");
    cyc(1'b0, 1'b1, 8'd255); chk("R2 hw T255", crc_out, 8'd53);
    cyc(1'b1, 1'b0, 8'd0);
    cyc(1'b0, 1'b1, 8'd128); chk("R2 hw T128", crc_out, 8'd140);

    // R5: exhaustive sweep of data with same-cycle clear on dirty register
    for (int d = 0; d < 256; d++) begin
      cyc(1'b0, 1'b1, 8'h5A ^ d[7:0]);
      cyc(1'b1, 1'b1, d[7:0]);
      chk("R5 clr+valid", crc_out, table_m[d]);
    end

    // R2: every data value on top of several non-zero registers
    for (int s = 1; s < 256; s += 37) begin
      for (int d = 0; d < 256; d++) begin
        cyc(1'b1, 1'b1, s[7:0]);
        cyc(1'b0, 1'b1, d[7:0]);
        expect_state("R2 step");
      end
    end

    // R3: idle cycles hold
    cyc(1'b1, 1'b1, 8'h3C);
    repeat (5) cyc(1'b0, 1'b0, 8'hFF);
    expect_state("R3 hold");

    // R4: clear-only zeroes and drops ok
    cyc(1'b1, 1'b0, 8'h77);
    expect_state("R4 clear");
    chk("R4 ok low", {7'd0, check_ok}, 8'h00);

    // R7: back-to-back random strings, with random gaps
    for (int n = 0; n < 40; n++) begin
      cyc(1'b1, 1'b0, 8'h00);
      @(negedge clk);
      for (int k = 0; k < 12; k++) begin
        logic [7:0] b;
        b = $urandom_range(0, 255);
        in_valid = 1'b1; in_data = b;
        @(posedge clk); #1;
        m_crc = table_m[m_crc ^ b]; m_started = 1'b1;
        chk("R7 ready", {7'd0, in_ready}, 8'h01);
        expect_state("R7 stream");
        @(negedge clk);
        in_valid = 1'b0;
        if ($urandom_range(0, 3) == 0) begin
          @(posedge clk); #1; expect_state("R3 gap"); @(negedge clk);
        end
      end
      // R8: append own CRC
      begin
        logic [7:0] tail;
        tail = m_crc;
        cyc(1'b0, 1'b1, tail);
        chk("R8 rand crc", crc_out, 8'h00);
        chk("R6 rand ok", {7'd0, check_ok}, 8'h01);
      end
    end

    // R8: identifier frame
    cyc(1'b1, 1'b0, 8'h00);
    for (int i = 0; i < 7; i++) cyc(1'b0, 1'b1, rom[i]);
    chk("R8 id crc", crc_out, 8'hA2);
    chk("R6 ok low nonzero", {7'd0, check_ok}, 8'h00);
    cyc(1'b0, 1'b1, rom[7]);
    chk("R8 id zero", crc_out, 8'h00);
    chk("R6 id ok", {7'd0, check_ok}, 8'h01);

    // R6: zero register after clear but no byte -> ok low
    cyc(1'b1, 1'b0, 8'h00);
    chk("R6 no byte", {7'd0, check_ok}, 8'h00);
    cyc(1'b0, 1'b1, 8'h00);
    chk("R6 zero byte", {7'd0, check_ok}, 8'h01);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule